// File: doc/BRIEF.md
# Processor Bus Cycle Monitor

This block watches a processor's external bus and never drives it. It samples the bus once per bus state, where one bus state spans a fixed number of input clocks (two by default). When an address strobe is seen, it captures the cycle definition: the space, direction and data/control signals, the lock signal, the two byte-lane enables and the top address bit. It holds that definition until the cycle is terminated by a ready indication. It then reports the cycle as one of eight kinds, together with its wait-state count and byte lanes, and raises a completion pulse that lasts one bus state.

Between cycles it reports whether the bus is idle, busy or granted away through hold acknowledge. Idle is inferred from the strobe and termination history, not read from a pin. While a cycle to I/O space with the top address bit high is in progress, it drives a coprocessor select. It also flags three protocol faults: a cycle shorter than two states, a new strobe that arrives before the previous cycle has terminated, and an illegal definition code. A running count of completed cycles lets a scoreboard line up events.

Top module: `bcm_monitor`

## Requirements
- R1: The bus is sampled on every STATE_CLKS-th rising clock edge after reset is released; all outputs change only on those sampling edges.
- R2: Definition encoding: mem_io_i=1 means memory, wr_rd_i=1 means write, dat_ctl_i=1 means data. Memory codes with wr_rd_i=0 (with either dat_ctl_i value) report kind 0 (read), or kind 1 when lock_i is high. Memory code dat_ctl_i=1, wr_rd_i=1 reports kind 2 (write), or kind 3 when lock_i is high.
- R3: I/O codes (mem_io_i=0) report by {dat_ctl_i, wr_rd_i}: 00 gives kind 6 (interrupt acknowledge), 01 gives kind 7 (halt or shutdown), 10 gives kind 4 (I/O read) and 11 gives kind 5 (I/O write).
- R4: proto_err_o is raised together with done_o when the reported cycle was an interrupt acknowledge with lock_i low, or used the illegal memory code dat_ctl_i=0, wr_rd_i=1. The illegal code is reported as kind 0 whatever lock_i is.
- R5: A cycle ends at the first sampling edge after its strobe state at which ready_i is high. done_o then rises for one bus state, and kind_o, waits_o and lanes_o hold that cycle's values until the next completion. waits_o equals the number of states between the strobe state and the ready state, and saturates at its maximum.
- R6: When ready_i is high in the same state as a strobe and no cycle is active, the cycle completes at once with short_err_o set and waits_o at 0.
- R7: A strobe while a cycle is active and ready_i is low raises overlap_err_o for one state. The old cycle is dropped without a completion, and the new cycle becomes active.
- R8: A strobe with ready_i high while a cycle is active completes the old cycle and starts the new one in the same state.
- R9: bus_status_o is 1 (busy) while a cycle is active and 0 (idle) once the latest cycle has terminated and no strobe has followed.
- R10: hold_ack_i sampled high forces bus_status_o to 2 (hold) ahead of busy and idle, without disturbing cycle tracking.
- R11: cop_sel_o is high while an active cycle was strobed with addr_hi_i=1 and mem_io_i=0. It is low otherwise.
- R12: cyc_cnt_o increments by one, modulo 2^CNT_W, at every completion. lanes_o reports the byte enables captured at the completed cycle's strobe.
- R13: ready_i sampled while no cycle is active and no strobe is present has no effect on any output.
- R14: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, STATE_CLKS periods per bus state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Address strobe, active high |
| mem_io_i | input | 1 | 1 = memory space, 0 = I/O space |
| wr_rd_i | input | 1 | 1 = write, 0 = read |
| dat_ctl_i | input | 1 | 1 = data, 0 = control or code |
| lock_i | input | 1 | Bus lock, active high |
| ben_i | input | 2 | Byte-lane enables, active high |
| addr_hi_i | input | 1 | Top address bit |
| ready_i | input | 1 | Cycle termination, active high |
| hold_ack_i | input | 1 | Hold acknowledge, active high |
| bus_status_o | output | 2 | 0 idle, 1 busy, 2 hold |
| cop_sel_o | output | 1 | Coprocessor select |
| done_o | output | 1 | Cycle completed, one bus state wide |
| kind_o | output | 3 | Kind of the last completed cycle |
| waits_o | output | WAIT_W | Wait states of the last completed cycle |
| lanes_o | output | 2 | Byte enables of the last completed cycle |
| short_err_o | output | 1 | Cycle shorter than two states |
| overlap_err_o | output | 1 | Strobe before the previous cycle terminated |
| proto_err_o | output | 1 | Unlocked interrupt acknowledge or illegal code |
| cyc_cnt_o | output | CNT_W | Completed-cycle count |

## Verification
The properties assume that bus inputs are steady across each bus state and that the bus state grid starts with the first clock after reset release. Under that assumption, anything sampled on a non-boundary edge is irrelevant, and the pulse-width and stability properties hold. The stimulus changes every input only on falling edges that begin a state, and holds it for exactly STATE_CLKS clocks. The definition signals are held constant throughout each cycle, and ready is raised only in the states a scenario intends.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic [2:0] {
        K_MEM_RD    = 3'd0,
        K_MEM_RD_LK = 3'd1,
        K_MEM_WR    = 3'd2,
        K_MEM_WR_LK = 3'd3,
        K_IO_RD     = 3'd4,
        K_IO_WR     = 3'd5,
        K_INTA      = 3'd6,
        K_HALT      = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HOLD = 2'd2
    } status_e;

    // Captured definition of one cycle
    typedef struct packed {
        kind_e      kind;
        logic       bad;
        logic       cop;
        logic [1:0] lanes;
    } cdef_t;

endpackage

// File: rtl/bcm_tick.sv
module bcm_tick #(
    parameter int STATE_CLKS = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int PH_W = (STATE_CLKS > 1) ? $clog2(STATE_CLKS) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(STATE_CLKS - 1);

    logic [PH_W-1:0] ph_d, ph_q;

    assign tick_o = (ph_q == LAST);

    always_comb begin
        ph_d = tick_o ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end
endmodule

// File: rtl/bcm_classify.sv
module bcm_classify
    import bcm_pkg::*;
(
    input  logic       mem_io_i,
    input  logic       wr_rd_i,
    input  logic       dat_ctl_i,
    input  logic       lock_i,
    input  logic       addr_hi_i,
    input  logic [1:0] ben_i,
    output cdef_t      def_o
);
    always_comb begin
        def_o       = '0;
        def_o.lanes = ben_i;
        def_o.cop   = addr_hi_i & ~mem_io_i;
        case ({mem_io_i, dat_ctl_i, wr_rd_i})
            3'b000: begin
                def_o.kind = K_INTA;
                def_o.bad  = ~lock_i;
            end
            3'b001: def_o.kind = K_HALT;
            3'b010: def_o.kind = K_IO_RD;
            3'b011: def_o.kind = K_IO_WR;
            3'b101: begin
                def_o.kind = K_MEM_RD;
                def_o.bad  = 1'b1;
            end
            3'b111: def_o.kind = lock_i ? K_MEM_WR_LK : K_MEM_WR;
            default: def_o.kind = lock_i ? K_MEM_RD_LK : K_MEM_RD;
        endcase
    end
endmodule

// File: rtl/bcm_tracker.sv
module bcm_tracker
    import bcm_pkg::*;
#(
    parameter int WAIT_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              strobe_i,
    input  logic              ready_i,
    input  logic              hold_i,
    input  cdef_t             def_i,
    output status_e           status_o,
    output logic              cop_o,
    output logic              done_o,
    output kind_e             kind_o,
    output logic [WAIT_W-1:0] waits_o,
    output logic [1:0]        lanes_o,
    output logic              short_o,
    output logic              ovl_o,
    output logic              proto_o,
    output logic [CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        logic              active;
        cdef_t             cur;
        logic [WAIT_W-1:0] elapsed;
        status_e           status;
        logic              cop;
        logic              done;
        kind_e             kind;
        logic [WAIT_W-1:0] waits;
        logic [1:0]        lanes;
        logic              short_e;
        logic              ovl_e;
        logic              proto_e;
        logic [CNT_W-1:0]  cnt;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d = q;
        if (tick_i) begin
            d.done    = 1'b0;
            d.short_e = 1'b0;
            d.ovl_e   = 1'b0;
            d.proto_e = 1'b0;
            // termination of the cycle in flight
            if (q.active && ready_i) begin
                d.done    = 1'b1;
                d.kind    = q.cur.kind;
                d.waits   = q.elapsed;
                d.lanes   = q.cur.lanes;
                d.proto_e = q.cur.bad;
                d.active  = 1'b0;
            end else if (q.active) begin
                d.elapsed = (&q.elapsed) ? q.elapsed : q.elapsed + 1'b1;
            end
            // a fresh strobe
            if (strobe_i) begin
                if (q.active && !ready_i) begin
                    d.ovl_e = 1'b1;
                end
                if (!q.active && ready_i) begin
                    d.done    = 1'b1;
                    d.short_e = 1'b1;
                    d.kind    = def_i.kind;
                    d.waits   = '0;
                    d.lanes   = def_i.lanes;
                    d.proto_e = def_i.bad;
                    d.active  = 1'b0;
                end else begin
                    d.active  = 1'b1;
                    d.cur     = def_i;
                    d.elapsed = '0;
                end
            end
            if (d.done) begin
                d.cnt = q.cnt + 1'b1;
            end
            d.cop    = d.active & d.cur.cop;
            d.status = hold_i   ? ST_HOLD :
                       d.active ? ST_BUSY : ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign status_o = q.status;
    assign cop_o    = q.cop;
    assign done_o   = q.done;
    assign kind_o   = q.kind;
    assign waits_o  = q.waits;
    assign lanes_o  = q.lanes;
    assign short_o  = q.short_e;
    assign ovl_o    = q.ovl_e;
    assign proto_o  = q.proto_e;
    assign cnt_o    = q.cnt;
endmodule

// File: rtl/bcm_monitor.sv
module bcm_monitor
    import bcm_pkg::*;
#(
    parameter int STATE_CLKS = 2,
    parameter int WAIT_W     = 8,
    parameter int CNT_W      = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              strobe_i,
    input  logic              mem_io_i,
    input  logic              wr_rd_i,
    input  logic              dat_ctl_i,
    input  logic              lock_i,
    input  logic [1:0]        ben_i,
    input  logic              addr_hi_i,
    input  logic              ready_i,
    input  logic              hold_ack_i,
    output logic [1:0]        bus_status_o,
    output logic              cop_sel_o,
    output logic              done_o,
    output logic [2:0]        kind_o,
    output logic [WAIT_W-1:0] waits_o,
    output logic [1:0]        lanes_o,
    output logic              short_err_o,
    output logic              overlap_err_o,
    output logic              proto_err_o,
    output logic [CNT_W-1:0]  cyc_cnt_o
);
    logic    tick;
    cdef_t   def_now;
    status_e status;
    kind_e   kind;

    bcm_tick #(.STATE_CLKS(STATE_CLKS)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    bcm_classify u_cls (
        .mem_io_i  (mem_io_i),
        .wr_rd_i   (wr_rd_i),
        .dat_ctl_i (dat_ctl_i),
        .lock_i    (lock_i),
        .addr_hi_i (addr_hi_i),
        .ben_i     (ben_i),
        .def_o     (def_now)
    );

    bcm_tracker #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_trk (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .strobe_i (strobe_i),
        .ready_i  (ready_i),
        .hold_i   (hold_ack_i),
        .def_i    (def_now),
        .status_o (status),
        .cop_o    (cop_sel_o),
        .done_o   (done_o),
        .kind_o   (kind),
        .waits_o  (waits_o),
        .lanes_o  (lanes_o),
        .short_o  (short_err_o),
        .ovl_o    (overlap_err_o),
        .proto_o  (proto_err_o),
        .cnt_o    (cyc_cnt_o)
    );

    assign bus_status_o = status;
    assign kind_o       = kind;
endmodule

// File: rtl/bcm_monitor_chk.sv
module bcm_monitor_chk #(
    parameter int WAIT_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              hold,
    input logic [1:0]        status,
    input logic              cop,
    input logic              done,
    input logic [WAIT_W-1:0] waits,
    input logic              short_e,
    input logic              ovl_e,
    input logic              proto_e,
    input logic [CNT_W-1:0]  cnt
);
    AST_QUIET_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(status) && $stable(done) && $stable(cnt) && $stable(cop))); // R1

    AST_PROTO_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        proto_e |-> done); // R4

    AST_SHORT_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        short_e |-> (done && waits == '0)); // R6

    AST_OVERLAP_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_e |-> (!done && status != 2'd0)); // R7

    AST_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick) && $past(hold)) |-> status == 2'd2); // R10

    AST_COP_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cop |-> status != 2'd0); // R11

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> cnt == CNT_W'($past(cnt) + 1'b1)); // R12
endmodule

bind bcm_monitor bcm_monitor_chk #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .tick    (tick),
    .hold    (hold_ack_i),
    .status  (bus_status_o),
    .cop     (cop_sel_o),
    .done    (done_o),
    .waits   (waits_o),
    .short_e (short_err_o),
    .ovl_e   (overlap_err_o),
    .proto_e (proto_err_o),
    .cnt     (cyc_cnt_o)
);

// File: tb/bcm_monitor_bench.sv
module bcm_monitor_bench;
    localparam int NCLK  = 2;
    localparam int WW    = 8;
    localparam int CW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 0, mio = 0, wr = 0, dc = 0, lk = 0, a23 = 0, rdy = 0, hld = 0;
    logic [1:0] be = 2'b00;

    logic [1:0]    status;
    logic          cop, done, short_e, ovl_e, proto_e;
    logic [2:0]    kind;
    logic [WW-1:0] waits;
    logic [1:0]    lanes;
    logic [CW-1:0] cnt;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bcm_monitor #(.STATE_CLKS(NCLK), .WAIT_W(WW), .CNT_W(CW)) u_bcm_monitor (
        .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .mem_io_i(mio),
        .wr_rd_i(wr), .dat_ctl_i(dc), .lock_i(lk), .ben_i(be), .addr_hi_i(a23),
        .ready_i(rdy), .hold_ack_i(hld), .bus_status_o(status), .cop_sel_o(cop),
        .done_o(done), .kind_o(kind), .waits_o(waits), .lanes_o(lanes),
        .short_err_o(short_e), .overlap_err_o(ovl_e), .proto_err_o(proto_e),
        .cyc_cnt_o(cnt)
    );

    // ---------------- behavioural reference model ----------------
    int m_ph;
    int pend[$];           // definition of the cycle in flight: {kind, bad, cop, lanes}
    int m_el;
    int m_status, m_cop, m_done, m_kind, m_waits, m_lanes, m_short, m_ovl, m_proto, m_cnt;

    function automatic int kind_of(logic m, logic w, logic d, logic l);
        if (!m) begin
            if (!d && !w) return 6;
            if (!d &&  w) return 7;
            return w ? 5 : 4;
        end
        if (!d && w) return 0;
        if (w) return l ? 3 : 2;
        return l ? 1 : 0;
    endfunction

    function automatic int bad_of(logic m, logic w, logic d, logic l);
        return ((!m && !d && !w && !l) || (m && !d && w)) ? 1 : 0;
    endfunction

    task automatic report(int k, int b, int l, int w, int s);
        m_done = 1; m_kind = k; m_proto = b; m_lanes = l; m_waits = w; m_short = s;
        m_cnt = (m_cnt + 1) % (1 << CW);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; pend.delete(); m_el = 0;
            m_status = 0; m_cop = 0; m_done = 0; m_kind = 0; m_waits = 0;
            m_lanes = 0; m_short = 0; m_ovl = 0; m_proto = 0; m_cnt = 0;
        end else begin
            bit boundary;
            boundary = (m_ph == NCLK - 1);
            m_ph = boundary ? 0 : m_ph + 1;
            if (boundary) begin
                int nk, nb;
                m_done = 0; m_short = 0; m_ovl = 0; m_proto = 0;
                nk = kind_of(mio, wr, dc, lk);
                nb = bad_of(mio, wr, dc, lk);
                if (pend.size() > 0 && rdy) begin
                    report(pend[0], pend[1], pend[3], m_el, 0);
                    pend.delete();
                end else if (pend.size() > 0) begin
                    if (m_el < (1 << WW) - 1) m_el++;
                end
                if (strobe) begin
                    if (pend.size() > 0) begin
                        m_ovl = 1;          // still in flight, ready low
                        pend.delete();
                    end
                    if (rdy && !m_done) begin
                        report(nk, nb, be, 0, 1);
                    end else begin
                        pend = '{nk, nb, (a23 && !mio) ? 1 : 0, int'(be)};
                        m_el = 0;
                    end
                end
                m_cop = (pend.size() > 0) ? pend[2] : 0;
                m_status = hld ? 2 : (pend.size() > 0 ? 1 : 0);
            end
        end
    end

    // ---------------- comparison on every clock ----------------
    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!finished) begin
            if (!rst_n) begin
                // R14: everything cleared in reset
                chk("R14", "reset outputs", {status, cop, done, kind, waits, lanes,
                    short_e, ovl_e, proto_e, cnt}, 0);
            end else begin
                chk("R9,R10", "status", status, m_status);
                chk("R11", "cop_sel", cop, m_cop);
                chk("R5", "done", done, m_done);
                chk("R2,R3", "kind", kind, m_kind);
                chk("R5", "waits", waits, m_waits);
                chk("R12", "lanes", lanes, m_lanes);
                chk("R6", "short_err", short_e, m_short);
                chk("R7", "overlap_err", ovl_e, m_ovl);
                chk("R4", "proto_err", proto_e, m_proto);
                chk("R12", "count", cnt, m_cnt);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic st(logic s, logic m, logic w, logic d, logic l, logic a,
                      logic [1:0] b, logic r, logic h);
        strobe = s; mio = m; wr = w; dc = d; lk = l; a23 = a; be = b; rdy = r; hld = h;
        repeat (NCLK) @(negedge clk);
    endtask

    task automatic quiet(int n, logic h);
        for (int i = 0; i < n; i++) st(0, 0, 0, 0, 0, 0, 2'b00, 0, h);
    endtask

    // full cycle: strobe state, n wait states, ready state
    task automatic cyc(logic m, logic w, logic d, logic l, logic a, logic [1:0] b, int n);
        st(1, m, w, d, l, a, b, 0, 0);
        for (int i = 0; i < n; i++) st(0, m, w, d, l, a, b, 0, 0);
        st(0, m, w, d, l, a, b, 1, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;                  // R1: state grid starts here
        quiet(2, 0);
        st(0, 0, 0, 0, 0, 0, 2'b11, 1, 0);   // R13: stray ready while idle
        st(0, 1, 1, 1, 0, 0, 2'b11, 1, 0);   // R13
        quiet(1, 0);
        cyc(1, 0, 1, 0, 0, 2'b11, 0);        // R2 data read
        cyc(1, 0, 0, 0, 0, 2'b01, 1);        // R2 code read
        cyc(1, 0, 1, 1, 0, 2'b10, 1);        // R2 locked read
        cyc(1, 1, 1, 0, 0, 2'b11, 2);        // R2 write
        cyc(1, 1, 1, 1, 1, 2'b01, 3);        // R2 locked write, high address in memory
        cyc(0, 0, 1, 0, 1, 2'b11, 1);        // R3 I/O read to coprocessor, R11
        cyc(0, 1, 1, 0, 1, 2'b10, 0);        // R3 I/O write to coprocessor, R11
        cyc(0, 1, 1, 0, 0, 2'b01, 2);        // R3 plain I/O write
        cyc(0, 0, 0, 1, 0, 2'b11, 0);        // R3 locked interrupt acknowledge
        cyc(0, 0, 0, 0, 0, 2'b11, 0);        // R4 unlocked interrupt acknowledge
        cyc(0, 1, 0, 0, 0, 2'b00, 0);        // R3 halt
        cyc(1, 1, 0, 1, 0, 2'b10, 1);        // R4 illegal memory code
        quiet(1, 0);
        st(1, 1, 0, 1, 0, 0, 2'b01, 1, 0);   // R6 short cycle
        st(1, 0, 0, 1, 0, 1, 2'b11, 1, 0);   // R6 short right after short
        quiet(1, 0);
        st(1, 1, 0, 1, 0, 0, 2'b11, 0, 0);   // R7 overlap
        st(1, 1, 1, 1, 0, 0, 2'b10, 0, 0);
        st(0, 1, 1, 1, 0, 0, 2'b10, 0, 0);
        st(0, 1, 1, 1, 0, 0, 2'b10, 1, 0);
        st(1, 0, 0, 1, 0, 1, 2'b11, 0, 0);   // R8 pipelined start
        st(1, 1, 0, 1, 0, 0, 2'b01, 1, 0);   // R8 old ends, new starts
        st(0, 1, 0, 1, 0, 0, 2'b01, 0, 0);
        st(0, 1, 0, 1, 0, 0, 2'b01, 1, 0);
        quiet(2, 1);                         // R10 hold while idle
        st(1, 0, 0, 1, 0, 1, 2'b11, 0, 1);   // R10 hold over a busy cycle
        st(0, 0, 0, 1, 0, 1, 2'b11, 0, 1);
        st(0, 0, 0, 1, 0, 1, 2'b11, 1, 0);
        cyc(1, 0, 1, 0, 0, 2'b11, 6);        // R5 long wait count
        quiet(3, 0);                          // R9 back to idle
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule